// File: doc/BRIEF.md
# Clock Frequency Ratio Meter

This block measures how many cycles of a fast reference clock fit into four periods of a slow low-power clock. The slow clock arrives asynchronously. It is resynchronised into the fast domain, and its rising edges mark the window boundaries. At the end of each window the cycle count is latched into a 13-bit result. Software turns the meter on and off through a single 32-bit control/status word, and the same word carries the result back.

Measurement runs only while software has set the enable bit and an external status input reports that the slow clock is present. While enabled, windows follow one another with no gap, and each completed window refreshes the result. Software converts the count into a frequency. With a 20 MHz reference and a 32768 Hz slow clock, the count is about 2440.

Top module: `clk_ratio_meter`

## Requirements
- R1: A write with `wr_en` high loads `wr_data[31]` into the enable bit. `rd_data[31]` shows the enable bit from the cycle after the write.
- R2: The slow clock passes through a two-flop synchroniser and a rising-edge detector. When the slow clock has a constant period of P fast cycles, the latched result equals 4·P.
- R3: After measurement becomes active, counting starts only at the next detected slow rising edge. The first result to appear is therefore a full 4·P count and never a partial one.
- R4: The result is read from `rd_data[12:0]`. It changes only when a window completes and otherwise holds its value, including while the meter is disabled.
- R5: The count saturates at 8191 and does not wrap. A window longer than 8191 fast cycles reads as 8191.
- R6: Counting happens only while the enable bit is 1 and `slow_present` is 1. At any other time the window logic idles and the result is not updated.
- R7: `rd_data[30:13]` always reads as zero.
- R8: `meas_valid` goes high when the first window completes and stays high until reset.
- R9: While the meter remains active, windows repeat back to back. After the slow period changes, the result follows the new period once a whole window at that period has elapsed.
- R10: After reset, `rd_data` is 0 and `meas_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_async | input | 1 | Slow clock, asynchronous to clk |
| slow_present | input | 1 | High when the external slow clock is available |
| wr_en | input | 1 | Write strobe for the control/status word |
| wr_data | input | 32 | Write data; only bit 31 (enable) is stored |
| rd_data | output | 32 | Control/status word: enable at 31, zeros at 30:13, result at 12:0 |
| meas_valid | output | 1 | At least one window has completed since reset |

## Verification
The bench uses the default parameters: two synchroniser stages, a four-period window, and the 13-bit result. It generates the slow clock from the fast clock with an exact integer period. This makes every expected count exactly 4·P, so the expected value can be computed directly. It sweeps every slow period from 2 to 40 fast cycles and then runs the nominal ratio. It also runs periods of 2047, 2048 and 2100, which sit on both sides of the saturation limit. Further cases change the period while the meter is running and withdraw either the enable bit or the presence flag.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

    localparam int CSR_W  = 32;
    localparam int RES_W  = 13;
    localparam int EN_BIT = 31;
    localparam int RSV_W  = CSR_W - RES_W - 1;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_ARM   = 2'd1,
        MS_COUNT = 2'd2
    } meas_state_t;

    typedef struct packed {
        logic             enable;
        logic [RSV_W-1:0] rsvd;
        logic [RES_W-1:0] result;
    } csr_view_t;

    function automatic logic [RES_W-1:0] sat_inc(input logic [RES_W-1:0] v);
        return (v == {RES_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/slow_edge_sync.sv
module slow_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign rise_pulse = chain[STAGES-1] & ~last_q;

    // R2: a detected edge never lasts more than one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/ratio_window.sv
module ratio_window
    import clkratio_pkg::*;
#(
    parameter int WINDOW_PERIODS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             edge_pulse,
    output logic [RES_W-1:0] result,
    output logic             valid
);
    localparam int EW = $clog2(WINDOW_PERIODS + 1);
    localparam logic [EW-1:0]    LAST_EDGE = EW'(WINDOW_PERIODS - 1);
    localparam logic [RES_W-1:0] CNT_MAX   = {RES_W{1'b1}};

    meas_state_t      st;
    logic [RES_W-1:0] cnt;
    logic [EW-1:0]    edges;
    logic [RES_W-1:0] result_q;
    logic             valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= MS_IDLE;
            cnt      <= '0;
            edges    <= '0;
            result_q <= '0;
            valid_q  <= 1'b0;
        end else if (!active) begin
            st    <= MS_IDLE;
            cnt   <= '0;
            edges <= '0;
        end else begin
            unique case (st)
                MS_IDLE: st <= MS_ARM;
                MS_ARM: begin
                    if (edge_pulse) begin
                        st    <= MS_COUNT;
                        cnt   <= RES_W'(1);
                        edges <= '0;
                    end
                end
                MS_COUNT: begin
                    if (edge_pulse && edges == LAST_EDGE) begin
                        result_q <= cnt;
                        valid_q  <= 1'b1;
                        cnt      <= RES_W'(1);
                        edges    <= '0;
                    end else begin
                        cnt <= sat_inc(cnt);
                        if (edge_pulse) edges <= edges + 1'b1;
                    end
                end
                default: st <= MS_IDLE;
            endcase
        end
    end

    assign result = result_q;
    assign valid  = valid_q;

    // R6: without an active measurement the counter rests at zero
    a_r6_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt == '0 && st == MS_IDLE));

    // R5: a saturated count stays at the limit until the window closes
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (active && st == MS_COUNT && !edge_pulse && cnt == CNT_MAX) |=> cnt == CNT_MAX);

    // R4: outside the counting state the latched result never moves
    a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
        (st != MS_COUNT) |=> $stable(result_q));

    // R8: valid is sticky
    a_r8_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> valid_q);

endmodule

// File: rtl/clk_ratio_meter.sv
module clk_ratio_meter
    import clkratio_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int WINDOW_PERIODS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_clk_async,
    input  logic        slow_present,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        meas_valid
);
    logic             en_q;
    logic             active;
    logic             rise;
    logic [RES_W-1:0] result;
    csr_view_t        view;

    always_ff @(posedge clk) begin
        if (rst)        en_q <= 1'b0;
        else if (wr_en) en_q <= wr_data[EN_BIT];
    end

    assign active = en_q & slow_present;

    slow_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_in   (slow_clk_async),
        .rise_pulse (rise)
    );

    ratio_window #(.WINDOW_PERIODS(WINDOW_PERIODS)) u_win (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .edge_pulse (rise),
        .result     (result),
        .valid      (meas_valid)
    );

    always_comb begin
        view.enable = en_q;
        view.rsvd   = '0;
        view.result = result;
    end

    assign rd_data = view;

    // R1: the enable bit reads back what the previous write stored
    a_r1_enable_readback: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[EN_BIT] == $past(wr_data[EN_BIT]));

    // R7: reserved bits stay zero
    a_r7_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[30:13] == '0);

endmodule

// File: tb/tb_clk_ratio_meter.sv
module tb_clk_ratio_meter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow = 1'b0;
    logic        present = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        meas_valid;

    int n_chk = 0;
    int n_bad = 0;
    int per_hi = 5;
    int per_lo = 5;
    int ph = 0;
    bit done = 0;

    clk_ratio_meter dut (
        .clk(clk), .rst(rst), .slow_clk_async(slow), .slow_present(present),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .meas_valid(meas_valid)
    );

    always #4 clk = ~clk;

    initial forever begin
        @(negedge clk);
        ph++;
        if (slow && ph >= per_hi) begin slow = 1'b0; ph = 0; end
        else if (!slow && ph >= per_lo) begin slow = 1'b1; ph = 0; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wcsr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_period(input int p);
        per_hi = p / 2;
        per_lo = p - p / 2;
    endtask

    function automatic logic [31:0] expect_cnt(input int p);
        return (4 * p > 8191) ? 32'd8191 : 32'(4 * p);
    endfunction

    task automatic measure(input string req, input int p);
        wcsr(32'h0);
        set_period(p);
        wait_cyc(2 * p + 4);
        wcsr(32'h8000_0000);
        wait_cyc(6 * p + 10);
        chk(req, 32'(rd_data[12:0]), expect_cnt(p));
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(1);
        chk("R10 rd_data", rd_data, 32'h0);
        chk("R10 valid", 32'(meas_valid), 32'd0);

        set_period(10);
        present = 1'b1;
        wait_cyc(20);
        wcsr(32'h8000_0000);
        chk("R1 enable readback", 32'(rd_data[31]), 32'd1);
        chk("R8 not valid yet", 32'(meas_valid), 32'd0);
        begin
            int lim = 0;
            while (!meas_valid && lim < 200) begin wait_cyc(1); lim++; end
        end
        chk("R3 first result full", 32'(rd_data[12:0]), 32'd40);
        chk("R8 valid after window", 32'(meas_valid), 32'd1);
        chk("R7 reserved bits", 32'(rd_data[30:13]), 32'd0);

        for (int p = 2; p <= 40; p++) begin
            measure("R2 sweep", p);
            chk("R7 reserved sweep", 32'(rd_data[30:13]), 32'd0);
        end

        wcsr(32'h0);
        chk("R1 disable readback", 32'(rd_data[31]), 32'd0);
        set_period(25);
        wait_cyc(300);
        chk("R4 hold while disabled", 32'(rd_data[12:0]), 32'd160);

        present = 1'b0;
        wcsr(32'h8000_0000);
        wait_cyc(300);
        chk("R6 no update without slow clock", 32'(rd_data[12:0]), 32'd160);
        present = 1'b1;
        wait_cyc(6 * 25 + 10);
        chk("R6 resumes with slow clock", 32'(rd_data[12:0]), 32'd100);

        set_period(33);
        wait_cyc(400);
        chk("R9 refresh to new period", 32'(rd_data[12:0]), 32'd132);
        set_period(17);
        wait_cyc(400);
        chk("R9 refresh to shorter period", 32'(rd_data[12:0]), 32'd68);

        measure("R2 nominal ratio", 610);
        measure("R5 below limit", 2047);
        measure("R5 at limit", 2048);
        measure("R5 beyond limit", 2100);
        chk("R8 valid sticky", 32'(meas_valid), 32'd1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule